// File: doc/BRIEF.md
# Power-Up Key Recovery Sequencer

This block controls the power-up path that recovers a device-unique key from uninitialised SRAM. The key is then used to decrypt a protected configuration image. Each step is a valid/ready exchange with a neighbouring unit, and the steps run in a fixed order:

1. Accept an encrypted image together with a challenge. The challenge is the base address of a window of SRAM words.
2. Read the start-up contents of that window as the noisy response.
3. Fetch the two helper words: the code-offset word first, then the hash-selector word.
4. Hand the response and both helper words to the key extractor.
5. Pass the recovered key to the decrypt engine.
6. Raise a configuration-done flag.

The sequencer never writes the SRAM. The response window is therefore sampled in its power-up state.

Enrollment needs the raw response. While the one-time lock is open, every SRAM word read during capture is mirrored on a readout port. Setting the lock closes that port for good. The lock register is cleared only by the power-on reset `por_ni` and not by the functional reset `rst_ni`. After that, the response reaches only the extractor.

A decode failure from the extractor drops the flow into an error state. So does any stage that stalls past a parameterised limit. In the error state the key is withheld and configuration is never signalled.

Top module: `puf_key_seq`

## Requirements
- R1: After `rst_ni` is released, the block is idle:
  - `img_ready_o` is 1.
  - All request/valid outputs, `cfg_done_o`, `err_o`, `dec_key_o` and `ext_resp_o` are 0.
- R2: Capture reads `RESP_WORDS` SRAM words at addresses base, base+1, …, in ascending order, one per accepted `sram_req_o`/`sram_ack_i` exchange. The address holds steady while a request waits. Word w is placed at response bits [w*DATA_W +: DATA_W].
- R3: While unlocked, `raw_valid_o` is 1 in each cycle an SRAM read is accepted, and `raw_data_o` equals `sram_rdata_i`. While locked, `raw_valid_o` and `raw_data_o` are both 0.
- R4: A `lock_set_i` pulse sets `locked_o` from the next cycle on. `rst_ni` never clears it; only `por_ni` does.
- R5: Helper words are fetched only after capture completes. The `hlp_sel_o`=0 word (code offset) is fetched first, then the `hlp_sel_o`=1 word (hash selector).
- R6: `ext_valid_o` stays high until `ext_ready_i`. While it is high, `ext_resp_o`, `ext_w1_o` and `ext_w2_o` carry the captured response and the two helper words. `ext_resp_o` is 0 at all other times.
- R7: If `ext_fail_i` is high with `ext_done_i`, `err_o` rises in the next cycle and stays high until reset. While `err_o` is high, `dec_valid_o`, `cfg_done_o` and `dec_key_o` stay 0.
- R8: `dec_key_o` carries the extracted key only while the decrypt stage is pending, from `dec_valid_o` rising until `dec_done_i`. It is 0 at every other time, and 0 again the cycle after `dec_done_i`.
- R9: `cfg_done_o` rises the cycle after `dec_done_i` and holds until `rst_ni`.
- R10: If a stage waits `WDOG_LIMIT` consecutive cycles without progress, the block enters the error state of R7. Its request output is high for exactly `WDOG_LIMIT` cycles.
- R11: `img_valid_i` and `chal_base_i` are ignored outside idle. `img_ready_o` is 0 there, and the running capture keeps its original base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async functional reset |
| por_ni | input | 1 | Active-low power-on reset, the only clear of the lock |
| img_valid_i | input | 1 | Encrypted image offered, starts a flow |
| img_ready_o | output | 1 | Idle, image accepted |
| chal_base_i | input | ADDR_W | Challenge: base address of the response window |
| sram_req_o | output | 1 | SRAM read request |
| sram_addr_o | output | ADDR_W | SRAM read address |
| sram_ack_i | input | 1 | SRAM read accepted, data valid |
| sram_rdata_i | input | DATA_W | SRAM start-up data |
| raw_valid_o | output | 1 | Enrollment readout strobe |
| raw_data_o | output | DATA_W | Enrollment readout data |
| lock_set_i | input | 1 | Close enrollment readout permanently |
| locked_o | output | 1 | Lock state |
| hlp_req_o | output | 1 | Helper word request |
| hlp_sel_o | output | 1 | 0 = code offset word, 1 = hash selector word |
| hlp_ack_i | input | 1 | Helper word accepted |
| hlp_data_i | input | RESP_W | Helper word data |
| ext_valid_o | output | 1 | Extractor job offered |
| ext_ready_i | input | 1 | Extractor accepted job |
| ext_resp_o | output | RESP_W | Noisy response to extractor |
| ext_w1_o | output | RESP_W | Code offset helper word |
| ext_w2_o | output | RESP_W | Hash selector helper word |
| ext_done_i | input | 1 | Extractor result strobe |
| ext_fail_i | input | 1 | Decode failure, with ext_done_i |
| ext_key_i | input | KEY_W | Recovered key, with ext_done_i |
| dec_valid_o | output | 1 | Decrypt job offered |
| dec_ready_i | input | 1 | Decrypt engine accepted job |
| dec_key_o | output | KEY_W | Key to decrypt engine |
| dec_done_i | input | 1 | Decrypt finished |
| cfg_done_o | output | 1 | Configuration may proceed |
| err_o | output | 1 | Flow aborted |

## Verification
The assertions assume that the neighbours never acknowledge a request the block is not making. They also assume that `ext_done_i` and `dec_done_i` arrive only while the matching stage waits. The bench responders follow both rules: each acknowledge or done is a single-cycle pulse, driven only after the bench has seen the matching request or wait at a falling edge. Stall delays are kept below the watchdog limit, except in the one test that exercises the time-out on purpose. The lock is set at most once per power-on reset, between flows.

// File: rtl/puf_seq_pkg.sv
package puf_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CAPT, ST_HLP1, ST_HLP2, ST_EXT_REQ, ST_EXT_WAIT,
    ST_DEC_REQ, ST_DEC_WAIT, ST_DONE, ST_ERR
  } seq_state_e;
endpackage

// File: rtl/puf_resp_capture.sv
module puf_resp_capture #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int WORDS  = 4,
  localparam int RESP_W = WORDS * DATA_W,
  localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              take_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic [RESP_W-1:0] resp_o
);
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      base_q <= base_i;
      idx_q  <= '0;
    end else if (take_i && !last_o) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign addr_o = base_q + ADDR_W'(idx_q);
  assign last_o = (idx_q == IDX_W'(WORDS - 1));

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 resp_o[w*DATA_W +: DATA_W] <= '0;
      else if (take_i && idx_q == IDX_W'(w))       resp_o[w*DATA_W +: DATA_W] <= rdata_i;
    end
  end
endmodule

// File: rtl/puf_stage_wdog.sv
module puf_stage_wdog #(
  parameter int LIMIT = 1024,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic progress_i,
  output logic expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!busy_i || progress_i) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = busy_i && !progress_i && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/puf_fuse_lock.sv
module puf_fuse_lock (
  input  logic clk_i,
  input  logic por_ni,
  input  logic set_i,
  output logic locked_o
);
  // one-way: only power-on clears it
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)    locked_o <= 1'b0;
    else if (set_i) locked_o <= 1'b1;
  end
endmodule

// File: rtl/puf_key_seq.sv
module puf_key_seq
  import puf_seq_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int RESP_WORDS = 8,
  parameter int KEY_W      = 32,
  parameter int WDOG_LIMIT = 1024,
  localparam int RESP_W    = RESP_WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              img_valid_i,
  output logic              img_ready_o,
  input  logic [ADDR_W-1:0] chal_base_i,
  output logic              sram_req_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  input  logic              sram_ack_i,
  input  logic [DATA_W-1:0] sram_rdata_i,
  output logic              raw_valid_o,
  output logic [DATA_W-1:0] raw_data_o,
  input  logic              lock_set_i,
  output logic              locked_o,
  output logic              hlp_req_o,
  output logic              hlp_sel_o,
  input  logic              hlp_ack_i,
  input  logic [RESP_W-1:0] hlp_data_i,
  output logic              ext_valid_o,
  input  logic              ext_ready_i,
  output logic [RESP_W-1:0] ext_resp_o,
  output logic [RESP_W-1:0] ext_w1_o,
  output logic [RESP_W-1:0] ext_w2_o,
  input  logic              ext_done_i,
  input  logic              ext_fail_i,
  input  logic [KEY_W-1:0]  ext_key_i,
  output logic              dec_valid_o,
  input  logic              dec_ready_i,
  output logic [KEY_W-1:0]  dec_key_o,
  input  logic              dec_done_i,
  output logic              cfg_done_o,
  output logic              err_o
);
  seq_state_e state_q, nxt_norm, state_d;
  logic [RESP_W-1:0] resp, w1_q, w2_q;
  logic [KEY_W-1:0]  key_q;
  logic cap_take, cap_last, cap_start, busy, progress, expire;

  assign cap_start = (state_q == ST_IDLE) && img_valid_i;
  assign cap_take  = (state_q == ST_CAPT) && sram_ack_i;

  puf_resp_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(RESP_WORDS)) u_cap (
    .clk_i, .rst_ni, .start_i(cap_start), .base_i(chal_base_i), .take_i(cap_take),
    .rdata_i(sram_rdata_i), .addr_o(sram_addr_o), .last_o(cap_last), .resp_o(resp)
  );

  puf_fuse_lock u_lock (.clk_i, .por_ni, .set_i(lock_set_i), .locked_o);

  always_comb begin
    nxt_norm = state_q;
    unique case (state_q)
      ST_IDLE:     if (img_valid_i)               nxt_norm = ST_CAPT;
      ST_CAPT:     if (sram_ack_i && cap_last)    nxt_norm = ST_HLP1;
      ST_HLP1:     if (hlp_ack_i)                 nxt_norm = ST_HLP2;
      ST_HLP2:     if (hlp_ack_i)                 nxt_norm = ST_EXT_REQ;
      ST_EXT_REQ:  if (ext_ready_i)               nxt_norm = ST_EXT_WAIT;
      ST_EXT_WAIT: if (ext_done_i)                nxt_norm = ext_fail_i ? ST_ERR : ST_DEC_REQ;
      ST_DEC_REQ:  if (dec_ready_i)               nxt_norm = ST_DEC_WAIT;
      ST_DEC_WAIT: if (dec_done_i)                nxt_norm = ST_DONE;
      default:                                    nxt_norm = state_q;
    endcase
  end

  assign busy     = !(state_q inside {ST_IDLE, ST_DONE, ST_ERR});
  assign progress = (nxt_norm != state_q) || cap_take;

  puf_stage_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
    .clk_i, .rst_ni, .busy_i(busy), .progress_i(progress), .expire_o(expire)
  );

  assign state_d = expire ? ST_ERR : nxt_norm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w1_q <= '0;
      w2_q <= '0;
    end else begin
      if (state_q == ST_HLP1 && hlp_ack_i) w1_q <= hlp_data_i;
      if (state_q == ST_HLP2 && hlp_ack_i) w2_q <= hlp_data_i;
    end
  end

  // key lives only from extraction until decrypt finishes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                         key_q <= '0;
    else if (state_d == ST_ERR || state_d == ST_DONE)    key_q <= '0;
    else if (state_q == ST_EXT_WAIT && ext_done_i)       key_q <= ext_key_i;
  end

  assign img_ready_o = (state_q == ST_IDLE);
  assign sram_req_o  = (state_q == ST_CAPT);
  assign raw_valid_o = cap_take && !locked_o;
  assign raw_data_o  = raw_valid_o ? sram_rdata_i : '0;
  assign hlp_req_o   = (state_q == ST_HLP1) || (state_q == ST_HLP2);
  assign hlp_sel_o   = (state_q == ST_HLP2);
  assign ext_valid_o = (state_q == ST_EXT_REQ);
  assign ext_resp_o  = ext_valid_o ? resp : '0;
  assign ext_w1_o    = w1_q;
  assign ext_w2_o    = w2_q;
  assign dec_valid_o = (state_q == ST_DEC_REQ);
  assign dec_key_o   = (state_q inside {ST_DEC_REQ, ST_DEC_WAIT}) ? key_q : '0;
  assign cfg_done_o  = (state_q == ST_DONE);
  assign err_o       = (state_q == ST_ERR);
endmodule

// File: rtl/puf_key_seq_chk.sv
module puf_key_seq_chk #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int RESP_WORDS = 8,
  parameter int KEY_W      = 32,
  parameter int WDOG_LIMIT = 1024,
  localparam int RESP_W    = RESP_WORDS * DATA_W,
  localparam int CW        = $clog2(WDOG_LIMIT + 2)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_ni,
  input logic              img_ready_o,
  input logic              sram_req_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_ack_i,
  input logic              raw_valid_o,
  input logic [DATA_W-1:0] raw_data_o,
  input logic              locked_o,
  input logic              hlp_req_o,
  input logic              hlp_ack_i,
  input logic              ext_valid_o,
  input logic              ext_ready_i,
  input logic [RESP_W-1:0] ext_resp_o,
  input logic              dec_valid_o,
  input logic              dec_ready_i,
  input logic [KEY_W-1:0]  dec_key_o,
  input logic              cfg_done_o,
  input logic              err_o
);
  logic stall;
  logic [CW-1:0] stall_cnt;
  assign stall = (sram_req_o && !sram_ack_i) || (hlp_req_o && !hlp_ack_i) ||
                 (ext_valid_o && !ext_ready_i) || (dec_valid_o && !dec_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   stall_cnt <= '0;
    else if (!stall)                               stall_cnt <= '0;
    else if (stall_cnt != CW'(WDOG_LIMIT))         stall_cnt <= stall_cnt + 1'b1;
  end

  AST_RAW_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> (!raw_valid_o && raw_data_o == '0)); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!por_ni)
    locked_o |=> locked_o); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_req_o && !sram_ack_i) |=> (sram_req_o && $stable(sram_addr_o)) || err_o); // R2
  AST_EXT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_valid_o && !ext_ready_i) |=> (ext_valid_o && $stable(ext_resp_o)) || err_o); // R6
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!cfg_done_o && !dec_valid_o && dec_key_o == '0)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R7
  AST_CFG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_o |=> cfg_done_o); // R9
  AST_KEY_GONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_o |-> dec_key_o == '0); // R8
  AST_ONE_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({img_ready_o, sram_req_o, hlp_req_o, ext_valid_o, dec_valid_o})); // R5
  AST_WDOG_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_cnt == CW'(WDOG_LIMIT)) |-> err_o); // R10
endmodule

bind puf_key_seq puf_key_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESP_WORDS(RESP_WORDS),
  .KEY_W(KEY_W), .WDOG_LIMIT(WDOG_LIMIT)
) u_chk (.*);

// File: tb/puf_key_seq_bench.sv
module puf_key_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 8, NW = 4, KW = 16, WL = 16;
  localparam int RW = NW * DW;

  logic clk = 0, rst_ni = 0, por_ni = 0;
  logic img_valid_i = 0, img_ready_o;
  logic [AW-1:0] chal_base_i = '0, sram_addr_o;
  logic sram_req_o, sram_ack_i = 0;
  logic [DW-1:0] sram_rdata_i = '0, raw_data_o;
  logic raw_valid_o, lock_set_i = 0, locked_o;
  logic hlp_req_o, hlp_sel_o, hlp_ack_i = 0;
  logic [RW-1:0] hlp_data_i = '0, ext_resp_o, ext_w1_o, ext_w2_o;
  logic ext_valid_o, ext_ready_i = 0, ext_done_i = 0, ext_fail_i = 0;
  logic [KW-1:0] ext_key_i = '0, dec_key_o;
  logic dec_valid_o, dec_ready_i = 0, dec_done_i = 0, cfg_done_o, err_o;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  puf_key_seq #(.ADDR_W(AW), .DATA_W(DW), .RESP_WORDS(NW), .KEY_W(KW), .WDOG_LIMIT(WL))
    u_puf_key_seq (.clk_i(clk), .*);

  typedef struct packed {
    logic [AW-1:0] base;
    logic [KW-1:0] key;
    logic          fail;
    logic [3:0]    dly;
    logic          lock;
    logic          poke;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{base: 8'h10, key: 16'hBEEF, fail: 1'b0, dly: 4'd0, lock: 1'b0, poke: 1'b0},
    '{base: 8'hFE, key: 16'h1234, fail: 1'b0, dly: 4'd3, lock: 1'b0, poke: 1'b1},
    '{base: 8'h40, key: 16'hA5A5, fail: 1'b1, dly: 4'd1, lock: 1'b1, poke: 1'b0},
    '{base: 8'h7C, key: 16'h0F0F, fail: 1'b0, dly: 4'd5, lock: 1'b1, poke: 1'b0}
  };

  function automatic logic [DW-1:0] sram_val(input logic [AW-1:0] a);
    return (a * 8'd3) ^ 8'h5C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic stall(input int n, input logic req, input string tag);
    for (int i = 0; i < n; i++) begin
      chk(req, tag, 0, 1);
      @(negedge clk);
    end
  endtask

  task automatic run_flow(input vec_t v);
    logic [RW-1:0] exp_resp;
    logic [RW-1:0] w1, w2;
    w1 = 32'hC0DE_0000 | RW'(v.base);
    w2 = 32'h0000_5A00 ^ RW'(v.key);
    exp_resp = '0;
    chk(img_ready_o == 1, "R1 idle ready", img_ready_o, 1);
    img_valid_i = 1; chal_base_i = v.base;
    @(negedge clk);
    img_valid_i = 0;
    for (int w = 0; w < NW; w++) begin
      if (v.poke) begin
        img_valid_i = 1; chal_base_i = ~v.base;
      end
      for (int i = 0; i < v.dly; i++) begin
        chk(sram_req_o == 1 && img_ready_o == 0, "R11 busy not ready", img_ready_o, 0);
        @(negedge clk);
      end
      img_valid_i = 0;
      chk(sram_req_o && sram_addr_o == v.base + AW'(w), "R2 address order", sram_addr_o, v.base + AW'(w));
      sram_ack_i = 1; sram_rdata_i = sram_val(sram_addr_o);
      exp_resp[w*DW +: DW] = sram_rdata_i;
      #1;
      if (locked_o) chk(raw_valid_o == 0 && raw_data_o == 0, "R3 raw blocked", raw_data_o, 0);
      else          chk(raw_valid_o == 1 && raw_data_o == sram_rdata_i, "R3 raw readout", raw_data_o, sram_rdata_i);
      @(negedge clk);
      sram_ack_i = 0;
    end
    chk(sram_req_o == 0 && hlp_req_o && hlp_sel_o == 0, "R5 code offset first", hlp_sel_o, 0);
    stall(v.dly, hlp_req_o, "R5 helper wait");
    hlp_ack_i = 1; hlp_data_i = w1;
    @(negedge clk);
    chk(hlp_req_o && hlp_sel_o == 1, "R5 selector second", hlp_sel_o, 1);
    hlp_data_i = w2;
    @(negedge clk);
    hlp_ack_i = 0;
    chk(ext_valid_o && ext_resp_o == exp_resp, "R6 response to extractor", ext_resp_o, exp_resp);
    chk(ext_w1_o == w1 && ext_w2_o == w2, "R6 helper words", ext_w2_o, w2);
    chk(dec_key_o == 0, "R8 no key before decrypt", dec_key_o, 0);
    stall(v.dly, ext_valid_o, "R6 extractor hold");
    chk(ext_resp_o == exp_resp, "R6 response held", ext_resp_o, exp_resp);
    ext_ready_i = 1;
    @(negedge clk);
    ext_ready_i = 0;
    chk(ext_valid_o == 0 && ext_resp_o == 0, "R6 response hidden after accept", ext_resp_o, 0);
    ext_done_i = 1; ext_fail_i = v.fail; ext_key_i = v.key;
    @(negedge clk);
    ext_done_i = 0; ext_fail_i = 0; ext_key_i = '0;
    if (v.fail) begin
      chk(err_o && !dec_valid_o && dec_key_o == 0 && !cfg_done_o, "R7 decode failure", err_o, 1);
      repeat (3) @(negedge clk);
      chk(err_o && !cfg_done_o, "R7 error sticky", cfg_done_o, 0);
      return;
    end
    chk(dec_valid_o && dec_key_o == v.key, "R8 key to decrypt", dec_key_o, v.key);
    stall(v.dly, dec_valid_o, "R8 decrypt wait");
    dec_ready_i = 1;
    @(negedge clk);
    dec_ready_i = 0;
    chk(!dec_valid_o && dec_key_o == v.key && !cfg_done_o, "R8 key held while decrypting", dec_key_o, v.key);
    dec_done_i = 1;
    @(negedge clk);
    dec_done_i = 0;
    chk(cfg_done_o == 1 && !err_o, "R9 configure done", cfg_done_o, 1);
    chk(dec_key_o == 0, "R8 key cleared", dec_key_o, 0);
    repeat (3) @(negedge clk);
    chk(cfg_done_o == 1, "R9 done sticky", cfg_done_o, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int n;
    repeat (2) @(negedge clk);
    por_ni = 1; rst_ni = 1;
    @(negedge clk);
    chk(img_ready_o && !sram_req_o && !hlp_req_o && !ext_valid_o && !dec_valid_o,
        "R1 reset outputs", {sram_req_o, hlp_req_o, ext_valid_o, dec_valid_o}, 0);
    chk(!cfg_done_o && !err_o && dec_key_o == 0 && ext_resp_o == 0 && !locked_o,
        "R1 reset flags", {cfg_done_o, err_o}, 0);

    foreach (VECS[k]) begin
      if (VECS[k].lock && !locked_o) begin
        lock_set_i = 1;
        @(negedge clk);
        lock_set_i = 0;
        chk(locked_o == 1, "R4 lock set", locked_o, 1);
      end
      run_flow(VECS[k]);
      do_reset();
      chk(locked_o == VECS[k].lock, "R4 rst_ni leaves lock", locked_o, VECS[k].lock);
    end

    // R10 helper stage stall
    img_valid_i = 1; chal_base_i = 8'h20;
    @(negedge clk);
    img_valid_i = 0;
    for (int w = 0; w < NW; w++) begin
      sram_ack_i = 1; sram_rdata_i = sram_val(sram_addr_o);
      @(negedge clk);
    end
    sram_ack_i = 0;
    n = 0;
    while (hlp_req_o && n < 40) begin
      n++;
      @(negedge clk);
    end
    chk(n == WL, "R10 stall length", n, WL);
    chk(err_o && dec_key_o == 0 && !cfg_done_o, "R10 timeout error", err_o, 1);
    do_reset();
    chk(err_o == 0 && img_ready_o, "R1 reset clears error", err_o, 0);

    // R4 only power-on reset opens the lock
    por_ni = 0;
    @(negedge clk);
    por_ni = 1;
    @(negedge clk);
    chk(locked_o == 0, "R4 power-on clears lock", locked_o, 1'b0);
    img_valid_i = 1; chal_base_i = 8'h33;
    @(negedge clk);
    img_valid_i = 0;
    sram_ack_i = 1; sram_rdata_i = 8'h9E;
    #1;
    chk(raw_valid_o && raw_data_o == 8'h9E, "R3 readout reopened", raw_data_o, 8'h9E);
    @(negedge clk);
    sram_ack_i = 0;
    do_reset();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule